// File: doc/BRIEF.md
# Hierarchical Ping-Pong Tree Arbiter

This block picks one winner among N requesters once per cell time slot of a packet switch scheduler. It is a binary tree of two-input decision cells. Each cell holds one preference bit. The cells are packed three to a four-input group: two leaf cells and one cell that decides between the two pairs. Groups are stacked in layers. A single two-input cell caps the tree when N is an odd power of two.

The request OR-tree climbs toward the root and the grant descends to the inputs in the same cycle, so no register sits on the request-to-grant path. Each cell gates its own local decision with the grants from above as its last stage.

The preference bits are the only state. They change only at a clock edge where the slot strobe is high. A cell that wins toggles its bit so that its other side is favoured next time. A cell that has no request, or whose group lost above it, keeps its bit. With every input requesting, this gives an interleaved order rather than a sequential one.

Top module: `ppt_arbiter`

## Requirements
- R1: The grant vector `gnt` has at most one bit set in every cycle.
- R2: A grant bit is only set for an input whose `req` bit is set in the same cycle.
- R3: `gnt` is zero when `req` is zero, and non-zero whenever any `req` bit is set.
- R4: Reset clears every preference bit to favour the lower-numbered side, so the first decision after reset with all inputs requesting grants input 0 (`gnt` bit 0).
- R5: When the slot strobe is low at an edge, no preference bit changes, so an unchanged `req` keeps an unchanged `gnt` in the next cycle.
- R6: With only inputs 0..3 requesting on every slot from a cleared state, they are served in the repeating order 0, 2, 1, 3. With all N inputs requesting on every slot, slot k grants the input whose index is k with its log2(N) bits reversed.
- R7: A cell whose group was not granted from above keeps its preference bit across the slot.
- R8: A cell with no request on either side keeps its preference bit across the slot.
- R9: A cell that grants one side at a slot strobe favours the other side afterwards. Preference bit value 0 favours the lower input and 1 favours the upper input.
- R10: `gnt` follows a change of `req` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot | input | 1 | Cell time slot strobe; preference bits update at an edge where it is high |
| req | input | N | Request bit per input |
| gnt | output | N | One-hot or zero grant vector |

## Verification
The grant is combinational, so every grant check is sampled a quarter period after the inputs change, before the next edge (R10). A preference bit set at a slot edge shows up in the grant of the very next cycle. The bench therefore advances its reference tree right after each edge where the strobe was high and compares in the following cycle. Two widths are checked against that model: 16 inputs, built from whole four-input layers, and 8 inputs, capped by a single two-input cell. The directed sequences for R4, R6 and R7 state their expected grants cycle by cycle.

// File: rtl/ppt_pkg.sv
package ppt_pkg;

    // Preference held in each two-input cell
    typedef enum logic {
        FAV_LOW  = 1'b0,
        FAV_HIGH = 1'b1
    } pref_e;

    // Local decision of a cell, before the upper-layer grants are applied
    typedef struct packed {
        logic hi;
        logic lo;
    } pair_gnt_t;

    function automatic pair_gnt_t decide(input logic [1:0] r, input pref_e p);
        pair_gnt_t d;
        d.lo = r[0] & (~r[1] | (p == FAV_LOW));
        d.hi = r[1] & ~d.lo;
        return d;
    endfunction

endpackage

// File: rtl/ppt_cell.sv
module ppt_cell
    import ppt_pkg::*;
#(
    parameter int UPW = 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           slot,
    input  logic [1:0]     req,
    input  logic [UPW-1:0] up_gnt,
    output logic [1:0]     gnt
);
    pref_e     pref_q;
    pair_gnt_t loc;
    logic      all_up;

    // local decision does not wait on the upper grants
    assign loc    = decide(req, pref_q);
    assign all_up = &up_gnt;
    // upper grants join at the final gate stage
    assign gnt    = {loc.hi & all_up, loc.lo & all_up};

    always_ff @(posedge clk) begin
        if (rst) begin
            pref_q <= FAV_LOW;
        end else if (slot && all_up && (loc.lo || loc.hi)) begin
            pref_q <= loc.lo ? FAV_HIGH : FAV_LOW;
        end
    end
endmodule

// File: rtl/ppt_quad.sv
module ppt_quad (
    input  logic       clk,
    input  logic       rst,
    input  logic       slot,
    input  logic [3:0] req,
    input  logic       grp_gnt,
    output logic       grp_req,
    output logic [3:0] gnt
);
    logic [1:0] pair_req;
    logic [1:0] pair_gnt;

    assign pair_req[0] = req[0] | req[1];
    assign pair_req[1] = req[2] | req[3];
    assign grp_req     = |req;

    ppt_cell #(.UPW(1)) u_mid (
        .clk(clk), .rst(rst), .slot(slot),
        .req(pair_req), .up_gnt(grp_gnt), .gnt(pair_gnt)
    );

    for (genvar p = 0; p < 2; p++) begin : g_leaf
        ppt_cell #(.UPW(2)) u_leaf (
            .clk(clk), .rst(rst), .slot(slot),
            .req(req[2*p +: 2]),
            .up_gnt({grp_gnt, pair_gnt[p]}),
            .gnt(gnt[2*p +: 2])
        );
    end
endmodule

// File: rtl/ppt_tree.sv
module ppt_tree #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         slot,
    input  logic [N-1:0] req,
    input  logic         up_gnt,
    output logic         grp_req,
    output logic [N-1:0] gnt
);
    localparam int LG = $clog2(N);

    if (N == 2) begin : g_cell
        ppt_cell #(.UPW(1)) u_cell (
            .clk(clk), .rst(rst), .slot(slot),
            .req(req), .up_gnt(up_gnt), .gnt(gnt)
        );
        assign grp_req = |req;
    end else if (N == 4) begin : g_quad
        ppt_quad u_quad (
            .clk(clk), .rst(rst), .slot(slot),
            .req(req), .grp_gnt(up_gnt), .grp_req(grp_req), .gnt(gnt)
        );
    end else if ((LG % 2) == 0) begin : g_four
        localparam int SUB = N / 4;
        logic [3:0] sub_req;
        logic [3:0] sub_gnt;
        for (genvar s = 0; s < 4; s++) begin : g_sub
            ppt_tree #(.N(SUB)) u_sub (
                .clk(clk), .rst(rst), .slot(slot),
                .req(req[s*SUB +: SUB]), .up_gnt(sub_gnt[s]),
                .grp_req(sub_req[s]), .gnt(gnt[s*SUB +: SUB])
            );
        end
        ppt_quad u_top (
            .clk(clk), .rst(rst), .slot(slot),
            .req(sub_req), .grp_gnt(up_gnt), .grp_req(grp_req), .gnt(sub_gnt)
        );
    end else begin : g_two
        localparam int SUB = N / 2;
        logic [1:0] sub_req;
        logic [1:0] sub_gnt;
        for (genvar s = 0; s < 2; s++) begin : g_sub
            ppt_tree #(.N(SUB)) u_sub (
                .clk(clk), .rst(rst), .slot(slot),
                .req(req[s*SUB +: SUB]), .up_gnt(sub_gnt[s]),
                .grp_req(sub_req[s]), .gnt(gnt[s*SUB +: SUB])
            );
        end
        ppt_cell #(.UPW(1)) u_root (
            .clk(clk), .rst(rst), .slot(slot),
            .req(sub_req), .up_gnt(up_gnt), .gnt(sub_gnt)
        );
        assign grp_req = |sub_req;
    end
endmodule

// File: rtl/ppt_arbiter.sv
module ppt_arbiter #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         slot,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    logic any_req;

    // the root is granted whenever anything below it requests
    ppt_tree #(.N(N)) u_tree (
        .clk(clk), .rst(rst), .slot(slot),
        .req(req), .up_gnt(any_req), .grp_req(any_req), .gnt(gnt)
    );
endmodule

// File: rtl/ppt_arbiter_chk.sv
module ppt_arbiter_chk #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         slot,
    input logic [N-1:0] req,
    input logic [N-1:0] gnt
);
    // R1
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    // R2
    gnt_requested_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);

    // R3
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req == '0) |-> (gnt == '0));

    // R3
    busy_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (req != '0) |-> (gnt != '0));

    // R4
    reset_pref_chk: assert property (@(posedge clk)
        ($past(rst) && !rst && (&req)) |-> gnt[0]);

    // R5
    hold_no_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(slot) && $stable(req)) |-> $stable(gnt));
endmodule

bind ppt_arbiter ppt_arbiter_chk #(.N(N)) u_chk (
    .clk(clk), .rst(rst), .slot(slot), .req(req), .gnt(gnt)
);

// File: tb/ppt_arbiter_test.sv
module ppt_arbiter_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slot = 1'b0;
    logic [15:0] req16 = '0;
    logic [7:0]  req8 = '0;
    logic [15:0] gnt16;
    logic [7:0]  gnt8;

    int  checks = 0;
    int  fails = 0;
    bit  done = 0;
    int  fl[2][16];

    always #(CLK_P/2) clk = ~clk;

    ppt_arbiter #(.N(16)) uut (
        .clk(clk), .rst(rst), .slot(slot), .req(req16), .gnt(gnt16)
    );
    ppt_arbiter #(.N(8)) uut8 (
        .clk(clk), .rst(rst), .slot(slot), .req(req8), .gnt(gnt8)
    );

    // behavioural heap-indexed tree; w selects the model copy
    function automatic logic [15:0] model(input int w, input int n,
                                          input logic [15:0] r, input bit upd);
        logic nr[32];
        logic ng[32];
        logic [15:0] res = '0;
        for (int i = 0; i < n; i++) nr[n+i] = r[i];
        for (int k = n-1; k >= 1; k--) nr[k] = nr[2*k] | nr[2*k+1];
        ng[1] = nr[1];
        for (int k = 1; k < n; k++) begin
            logic lo;
            logic hi;
            lo = nr[2*k] & (!nr[2*k+1] || fl[w][k] == 0);
            hi = nr[2*k+1] & !lo;
            ng[2*k]   = ng[k] & lo;
            ng[2*k+1] = ng[k] & hi;
            if (upd && ng[k] && (lo || hi)) fl[w][k] = lo ? 1 : 0;
        end
        for (int i = 0; i < n; i++) res[i] = ng[n+i];
        return res;
    endfunction

    task automatic clear_model();
        for (int w = 0; w < 2; w++)
            for (int k = 0; k < 16; k++) fl[w][k] = 0;
    endtask

    task automatic chk(input bit ok, input string tag,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // drive at negedge, compare a quarter period later, advance model after edge
    task automatic step(input logic [15:0] r, input logic s);
        logic [15:0] e16;
        logic [15:0] e8;
        req16 = r;
        req8  = r[7:0];
        slot  = s;
        #(CLK_P/4);
        e16 = model(0, 16, r, 0);
        e8  = model(1, 8, {8'h00, r[7:0]}, 0);
        chk(gnt16 == e16, "R7 R8 R9 R10 model n16", gnt16, e16);
        chk({8'h00, gnt8} == e8, "R7 R8 R9 R10 model n8", {8'h00, gnt8}, e8);
        chk($countones(gnt16) <= 1, "R1 onehot", gnt16, e16);
        chk((gnt16 & ~r) == '0, "R2 requested", gnt16, r);
        chk((r == '0) == (gnt16 == '0), "R3 idle/busy", gnt16, e16);
        @(posedge clk);
        if (s && !rst) begin
            void'(model(0, 16, r, 1));
            void'(model(1, 8, {8'h00, r[7:0]}, 1));
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        req16 = '0; req8 = '0; slot = 1'b0;
        repeat (2) @(negedge clk);
        #(CLK_P/4);
        chk(gnt16 == '0, "R3 reset idle", gnt16, '0);
        clear_model();
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [15:0] bitrev4(input int k);
        logic [3:0] a;
        logic [3:0] b;
        a = 4'(k);
        for (int i = 0; i < 4; i++) b[i] = a[3-i];
        return 16'(1) << b;
    endfunction

    initial begin
        logic [15:0] hold;
        int order[4];
        clear_model();
        @(negedge clk);
        do_reset();

        // R4: first decision after reset, all requesting
        req16 = 16'hFFFF; req8 = 8'hFF; slot = 1'b0;
        #(CLK_P/4);
        chk(gnt16 == 16'h0001, "R4 n16 first grant", gnt16, 16'h0001);
        chk(gnt8 == 8'h01, "R4 n8 first grant", {8'h00, gnt8}, 16'h0001);
        @(negedge clk);

        // R5: no strobe keeps the grant
        hold = gnt16;
        for (int i = 0; i < 3; i++) begin
            step(16'hFFFF, 1'b0);
            chk(gnt16 == hold, "R5 hold without slot", gnt16, hold);
        end

        // R6: all inputs, bit-reversed order
        for (int k = 0; k < 16; k++) begin
            req16 = 16'hFFFF; req8 = 8'hFF; slot = 1'b1;
            #(CLK_P/4);
            chk(gnt16 == bitrev4(k), "R6 bit-reversed order", gnt16, bitrev4(k));
            @(posedge clk);
            void'(model(0, 16, 16'hFFFF, 1));
            void'(model(1, 8, 16'h00FF, 1));
            @(negedge clk);
        end

        // R6: four inputs, order 0,2,1,3
        do_reset();
        order = '{0, 2, 1, 3};
        for (int k = 0; k < 8; k++) begin
            req16 = 16'h000F; req8 = 8'h0F; slot = 1'b1;
            #(CLK_P/4);
            chk(gnt16 == (16'(1) << order[k%4]), "R6 quad order n16",
                gnt16, 16'(1) << order[k%4]);
            chk({8'h00, gnt8} == (16'(1) << order[k%4]), "R6 quad order n8",
                {8'h00, gnt8}, 16'(1) << order[k%4]);
            @(posedge clk);
            void'(model(0, 16, 16'h000F, 1));
            void'(model(1, 8, 16'h000F, 1));
            @(negedge clk);
        end

        // R7: losing group keeps its leaf preference
        do_reset();
        req16 = 16'h0033; req8 = 8'h33; slot = 1'b1;
        #(CLK_P/4);
        chk(gnt16 == 16'h0001, "R7 first", gnt16, 16'h0001);
        @(posedge clk); #1;
        void'(model(0, 16, 16'h0033, 1)); void'(model(1, 8, 16'h0033, 1));
        @(negedge clk); #(CLK_P/4);
        chk(gnt16 == 16'h0010, "R7 ungranted leaf kept", gnt16, 16'h0010);
        @(posedge clk); #1;
        void'(model(0, 16, 16'h0033, 1)); void'(model(1, 8, 16'h0033, 1));
        @(negedge clk); #(CLK_P/4);
        chk(gnt16 == 16'h0002, "R9 leaf toggled", gnt16, 16'h0002);
        @(posedge clk); #1;
        void'(model(0, 16, 16'h0033, 1)); void'(model(1, 8, 16'h0033, 1));
        @(negedge clk);

        // R8: idle leaf keeps its preference
        do_reset();
        for (int i = 0; i < 3; i++) step(16'h0004, 1'b1);
        step(16'h0003, 1'b0);
        req16 = 16'h0003; req8 = 8'h03; slot = 1'b0;
        #(CLK_P/4);
        chk(gnt16 == 16'h0001, "R8 idle leaf kept", gnt16, 16'h0001);
        @(negedge clk);

        // R10 and model: random patterns, random strobe
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] r;
            r = 16'($urandom);
            if ((i % 7) == 0) r = r & 16'($urandom);
            if ((i % 53) == 0) r = '0;
            step(r, 1'($urandom % 4 != 0));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule